// File: doc/BRIEF.md
# Virtual Supervisor Interrupt Pending Combiner

This block produces the four interrupt-pending bits that a hypervisor hart presents to a guest running at virtual supervisor level: the software bit (VSSIP), the timer bit (VSTIP), the external bit (VSEIP) and the guest-external summary bit (SGEIP). It owns the software-writable virtual pending bits, the per-guest external-interrupt enable vector and the 6-bit guest selector. Every other input is a live value from elsewhere in the hart: the time base, the guest time offset, the guest timer compare value, the guest external pending vector from an interrupt file, and a platform external line.

The pending outputs are combinational functions of the current state and inputs. The timer bit comes from comparing the offset time with the compare value. The external bit takes the guest pending bit picked by the selector and ORs it with the stored bit and the platform line. The summary bit is the OR of all enabled guest pending bits.

A plain write port loads the state. It has one strobe per register view and a shared 64-bit data word. The block also returns read views of the hypervisor pending, virtual pending, enable and guest pending registers. No data stream passes through the block, so it has no valid/ready handshake. All pins are plain control and status signals with no back-pressure.

Top module: `vsint_pending_combiner`

## Requirements
- R1: `vseip` equals the stored virtual external bit (virtual-pending view bit 10), OR the guest pending bit whose index is the selector, OR `plat_vseip`.
- R2: `vstip` equals the stored virtual timer bit (virtual-pending view bit 6), OR the result of an unsigned test that (`time_now` + `time_offset`) modulo 2^64 is at least `vs_cmp`.
- R3: `sgeip` is the OR of the guest pending view ANDed bitwise with the enable view.
- R4: Bit 0 of the guest pending view and of the enable view always reads 0. Only bits 1 to GEI_LEN can be nonzero. An enable write stores `wr_data[GEI_LEN:1]`.
- R5: A status write (`sel_hstatus`) loads the selector from `wr_data[17:12]` only when that value is at most GEI_LEN. A larger value leaves the selector unchanged.
- R6: In the hypervisor pending view, bit 2 is the stored VSSIP. Bits 6, 10 and 12 mirror `vstip`, `vseip` and `sgeip`, and all other bits read 0. A write through this view (`sel_hip`) changes only the stored VSSIP, taking it from `wr_data[2]`.
- R7: Stored VSSIP can be written through four paths. These are the machine pending alias (`sel_mip`, bit 2), the hypervisor pending alias (`sel_hip`, bit 2), the virtual supervisor alias (`sel_vsip`, bit 1) and a direct virtual-pending write (`sel_hvip`). The direct write stores bits 2, 6 and 10. At most one strobe is active in any cycle.
- R8: After reset, the stored VSSIP, VSTIP and VSEIP bits, the enable vector and the selector are all 0.
- R9: When the selector is 0, no guest pending bit contributes to `vseip`.
- R10: A register write becomes visible on the outputs in the cycle after its strobe. Changes on the live inputs appear on the outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 64 | Hart time base |
| time_offset | input | 64 | Guest time offset |
| vs_cmp | input | 64 | Guest timer compare value |
| gext_pend | input | GEI_LEN+1 | Guest external pending vector; bit 0 ignored |
| plat_vseip | input | 1 | Platform virtual external pending line |
| wr_data | input | 64 | Write data shared by all strobes |
| sel_hvip | input | 1 | Direct virtual-pending write strobe |
| sel_hip | input | 1 | Hypervisor pending alias write strobe |
| sel_mip | input | 1 | Machine pending alias write strobe |
| sel_vsip | input | 1 | Virtual supervisor pending alias write strobe |
| sel_hgeie | input | 1 | Enable vector write strobe |
| sel_hstatus | input | 1 | Status write strobe (selector field) |
| vssip | output | 1 | Combined software pending |
| vstip | output | 1 | Combined timer pending |
| vseip | output | 1 | Combined external pending |
| sgeip | output | 1 | Guest external summary pending |
| hip_rd | output | 64 | Hypervisor pending read view |
| hvip_rd | output | 64 | Virtual pending read view |
| hgeie_rd | output | 64 | Enable read view |
| hgeip_rd | output | 64 | Guest pending read view |

## Verification
The live inputs (time, offset, compare, guest pending, platform line) reach the outputs with no register in the path. The table-driven checks therefore change those inputs and sample after a short settle time in the same cycle. The strobes, the stored pending bits, the enable vector and the selector each pass through exactly one register. Each directed test raises its strobe on a falling edge, lowers it on the next falling edge and samples just after that. It also samples once before the rising edge to confirm that nothing changes in the write cycle itself.

// File: rtl/vsint_pkg.sv
package vsint_pkg;
  localparam int XLEN          = 64;
  localparam int BIT_SSW       = 2;   // software bit in hvip/hip/mip views
  localparam int BIT_TMR       = 6;
  localparam int BIT_EXT       = 10;
  localparam int BIT_GSUM      = 12;
  localparam int BIT_VS_SSW    = 1;   // software bit in the guest-level view
  localparam int SEL_LO        = 12;  // selector field low bit in status word
  localparam int SEL_W         = 6;

  typedef struct packed {
    logic ext;
    logic tmr;
    logic ssw;
  } vpend_t;
endpackage

// File: rtl/vsint_timer_cmp.sv
module vsint_timer_cmp #(
  parameter int TW = 64
) (
  input  logic [TW-1:0] base,
  input  logic [TW-1:0] offs,
  input  logic [TW-1:0] cmp,
  output logic          hit
);
  logic [TW-1:0] sum;
  always_comb begin
    sum = base + offs;          // wraps modulo 2^TW
    hit = (sum >= cmp);         // unsigned compare
  end
endmodule

// File: rtl/vsint_gext_sel.sv
module vsint_gext_sel
  import vsint_pkg::*;
#(
  parameter int GEI_LEN = 8
) (
  input  logic [GEI_LEN:0]   pend_in,
  input  logic [GEI_LEN:1]   enable,
  input  logic [SEL_W-1:0]   sel,
  output logic [GEI_LEN:0]   pend_vec,
  output logic               sel_hit,
  output logic               any_hit
);
  logic [GEI_LEN:1] match;
  logic [GEI_LEN:1] armed;

  assign pend_vec[0] = 1'b0;

  for (genvar i = 1; i <= GEI_LEN; i++) begin : g_lane
    assign pend_vec[i] = pend_in[i];
    assign match[i]    = pend_in[i] && (sel == SEL_W'(i));
    assign armed[i]    = pend_in[i] && enable[i];
  end

  assign sel_hit = |match;
  assign any_hit = |armed;
endmodule

// File: rtl/vsint_state_regs.sv
module vsint_state_regs
  import vsint_pkg::*;
#(
  parameter int GEI_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             sel_hvip,
  input  logic             sel_hip,
  input  logic             sel_mip,
  input  logic             sel_vsip,
  input  logic             sel_hgeie,
  input  logic             sel_hstatus,
  output vpend_t           vp_q,
  output logic [GEI_LEN:1] en_q,
  output logic [SEL_W-1:0] sel_q
);
  logic             ssw_wr;
  logic             ssw_d;
  logic [SEL_W-1:0] sel_new;
  logic             sel_ok;

  always_comb begin
    ssw_wr  = sel_hvip | sel_hip | sel_mip | sel_vsip;
    ssw_d   = (sel_hvip & wr_data[BIT_SSW]) | (sel_hip  & wr_data[BIT_SSW]) |
              (sel_mip  & wr_data[BIT_SSW]) | (sel_vsip & wr_data[BIT_VS_SSW]);
    sel_new = wr_data[SEL_LO +: SEL_W];
    sel_ok  = ({26'd0, sel_new} <= 32'(GEI_LEN));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vp_q  <= '0;
      en_q  <= '0;
      sel_q <= '0;
    end else begin
      if (ssw_wr) vp_q.ssw <= ssw_d;
      if (sel_hvip) begin
        vp_q.tmr <= wr_data[BIT_TMR];
        vp_q.ext <= wr_data[BIT_EXT];
      end
      if (sel_hgeie) en_q <= wr_data[GEI_LEN:1];
      if (sel_hstatus && sel_ok) sel_q <= sel_new;
    end
  end
endmodule

// File: rtl/vsint_pending_combiner.sv
module vsint_pending_combiner
  import vsint_pkg::*;
#(
  parameter int GEI_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [63:0]      time_now,
  input  logic [63:0]      time_offset,
  input  logic [63:0]      vs_cmp,
  input  logic [GEI_LEN:0] gext_pend,
  input  logic             plat_vseip,
  input  logic [63:0]      wr_data,
  input  logic             sel_hvip,
  input  logic             sel_hip,
  input  logic             sel_mip,
  input  logic             sel_vsip,
  input  logic             sel_hgeie,
  input  logic             sel_hstatus,
  output logic             vssip,
  output logic             vstip,
  output logic             vseip,
  output logic             sgeip,
  output logic [63:0]      hip_rd,
  output logic [63:0]      hvip_rd,
  output logic [63:0]      hgeie_rd,
  output logic [63:0]      hgeip_rd
);
  localparam int PAD = XLEN - GEI_LEN - 1;

  vpend_t           vp_q;
  logic [GEI_LEN:1] en_q;
  logic [SEL_W-1:0] vgein_q;
  logic [GEI_LEN:0] pend_vec;
  logic             tmr_hit;
  logic             gsel_hit;
  logic             gany_hit;

  vsint_state_regs #(.GEI_LEN(GEI_LEN)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data),
    .sel_hvip(sel_hvip), .sel_hip(sel_hip), .sel_mip(sel_mip),
    .sel_vsip(sel_vsip), .sel_hgeie(sel_hgeie), .sel_hstatus(sel_hstatus),
    .vp_q(vp_q), .en_q(en_q), .sel_q(vgein_q)
  );

  vsint_timer_cmp #(.TW(64)) u_tmr (
    .base(time_now), .offs(time_offset), .cmp(vs_cmp), .hit(tmr_hit)
  );

  vsint_gext_sel #(.GEI_LEN(GEI_LEN)) u_gext (
    .pend_in(gext_pend), .enable(en_q), .sel(vgein_q),
    .pend_vec(pend_vec), .sel_hit(gsel_hit), .any_hit(gany_hit)
  );

  always_comb begin
    vssip = vp_q.ssw;
    vstip = vp_q.tmr | tmr_hit;
    vseip = vp_q.ext | gsel_hit | plat_vseip;
    sgeip = gany_hit;

    hvip_rd          = '0;
    hvip_rd[BIT_SSW] = vp_q.ssw;
    hvip_rd[BIT_TMR] = vp_q.tmr;
    hvip_rd[BIT_EXT] = vp_q.ext;

    hip_rd           = '0;
    hip_rd[BIT_SSW]  = vp_q.ssw;
    hip_rd[BIT_TMR]  = vstip;
    hip_rd[BIT_EXT]  = vseip;
    hip_rd[BIT_GSUM] = sgeip;

    hgeie_rd = {{PAD{1'b0}}, en_q, 1'b0};
    hgeip_rd = {{PAD{1'b0}}, pend_vec};
  end
endmodule

// File: rtl/vsint_checker.sv
module vsint_checker #(
  parameter int GEI_LEN = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] wr_data,
  input logic        plat_vseip,
  input logic        sel_hvip,
  input logic        sel_hip,
  input logic        sel_mip,
  input logic        sel_vsip,
  input logic        sel_hgeie,
  input logic        sel_hstatus,
  input logic        vseip,
  input logic        sgeip,
  input logic [63:0] hip_rd,
  input logic [63:0] hvip_rd,
  input logic [63:0] hgeie_rd,
  input logic [63:0] hgeip_rd,
  input logic [5:0]  vgein_q
);
  a_r1_vseip_sources: assert property (@(posedge clk) disable iff (!rst_n)
    vseip == (hvip_rd[10] | plat_vseip | ((vgein_q != 6'd0) & hgeip_rd[vgein_q])));

  a_r3_summary: assert property (@(posedge clk) disable iff (!rst_n)
    sgeip == |(hgeip_rd & hgeie_rd));

  a_r4_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !hgeip_rd[0] && !hgeie_rd[0]);

  a_r5_sel_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    {26'd0, vgein_q} <= 32'(GEI_LEN));

  a_r5_illegal_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hstatus && ({26'd0, wr_data[17:12]} > 32'(GEI_LEN))) |=> $stable(vgein_q));

  a_r6_hip_write: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hip |=> (hvip_rd[2] == $past(wr_data[2])) && $stable(hvip_rd[10]) && $stable(hvip_rd[6]));

  a_r6_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    hip_rd[2] == hvip_rd[2] && hip_rd[10] == vseip && hip_rd[12] == sgeip);

  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_hvip, sel_hip, sel_mip, sel_vsip}));

  a_r7_vsip_path: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vsip |=> hvip_rd[2] == $past(wr_data[1]));

  a_r10_enable_next: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hgeie |=> hgeie_rd[GEI_LEN:1] == $past(wr_data[GEI_LEN:1]));
endmodule

bind vsint_pending_combiner vsint_checker #(.GEI_LEN(GEI_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .plat_vseip(plat_vseip),
  .sel_hvip(sel_hvip), .sel_hip(sel_hip), .sel_mip(sel_mip), .sel_vsip(sel_vsip),
  .sel_hgeie(sel_hgeie), .sel_hstatus(sel_hstatus), .vseip(vseip), .sgeip(sgeip),
  .hip_rd(hip_rd), .hvip_rd(hvip_rd), .hgeie_rd(hgeie_rd), .hgeip_rd(hgeip_rd),
  .vgein_q(vgein_q)
);

// File: tb/sim_vsint_pending_combiner.sv
`timescale 1ns/1ps
module sim_vsint_pending_combiner;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] time_now = '0, time_offset = '0, vs_cmp = '1, wr_data = '0;
  logic [8:0]  gext_pend = '0;
  logic plat_vseip = 1'b0;
  logic sel_hvip = 0, sel_hip = 0, sel_mip = 0, sel_vsip = 0, sel_hgeie = 0, sel_hstatus = 0;
  logic vssip, vstip, vseip, sgeip;
  logic [63:0] hip_rd, hvip_rd, hgeie_rd, hgeip_rd;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  vsint_pending_combiner #(.GEI_LEN(8)) u0 (
    .clk(clk), .rst_n(rst_n), .time_now(time_now), .time_offset(time_offset),
    .vs_cmp(vs_cmp), .gext_pend(gext_pend), .plat_vseip(plat_vseip),
    .wr_data(wr_data), .sel_hvip(sel_hvip), .sel_hip(sel_hip), .sel_mip(sel_mip),
    .sel_vsip(sel_vsip), .sel_hgeie(sel_hgeie), .sel_hstatus(sel_hstatus),
    .vssip(vssip), .vstip(vstip), .vseip(vseip), .sgeip(sgeip),
    .hip_rd(hip_rd), .hvip_rd(hvip_rd), .hgeie_rd(hgeie_rd), .hgeip_rd(hgeip_rd)
  );

  typedef struct packed {
    logic [63:0] t, o, c;
    logic [8:0]  g;
    logic        p, e_t, e_e, e_s;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{64'd100, 64'd0, 64'd100, 9'h000, 1'b0, 1'b1, 1'b0, 1'b0},
    '{64'd99,  64'd0, 64'd100, 9'h008, 1'b0, 1'b0, 1'b1, 1'b0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'd2, 9'h004, 1'b0, 1'b0, 1'b0, 1'b1},
    '{64'hFFFF_FFFF_FFFF_FFFE, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 9'h000, 1'b1, 1'b1, 1'b1, 1'b0},
    '{64'd0, 64'd0, 64'd0, 9'h001, 1'b0, 1'b1, 1'b0, 1'b0},
    '{64'd5, 64'hFFFF_FFFF_FFFF_FFFB, 64'd1, 9'h1F0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{64'h8000_0000_0000_0000, 64'd0, 64'h7FFF_FFFF_FFFF_FFFF, 9'h018, 1'b0, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef enum int {W_HVIP, W_HIP, W_MIP, W_VSIP, W_HGEIE, W_HST} wkind_t;

  task automatic wr(input wkind_t k, input logic [63:0] d);
    @(negedge clk);
    wr_data = d;
    case (k)
      W_HVIP:  sel_hvip = 1;
      W_HIP:   sel_hip = 1;
      W_MIP:   sel_mip = 1;
      W_VSIP:  sel_vsip = 1;
      W_HGEIE: sel_hgeie = 1;
      default: sel_hstatus = 1;
    endcase
    @(negedge clk);
    {sel_hvip, sel_hip, sel_mip, sel_vsip, sel_hgeie, sel_hstatus} = '0;
    wr_data = '0;
    #1;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R8: reset state
    chk("R8 hvip_rd", hvip_rd, 64'd0);
    chk("R8 hgeie_rd", hgeie_rd, 64'd0);
    chk("R8 hip_rd", hip_rd, 64'd0);
    chk("R8 vssip", {63'd0, vssip}, 64'd0);

    // set enables bits 2 and 4, selector 3
    wr(W_HGEIE, 64'h14);
    wr(W_HST, 64'd3 << 12);
    chk("R4 hgeie_rd", hgeie_rd, 64'h14);

    // table: R1, R2, R3
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      time_now = VECS[i].t; time_offset = VECS[i].o; vs_cmp = VECS[i].c;
      gext_pend = VECS[i].g; plat_vseip = VECS[i].p;
      #1;
      chk("R2 vstip", {63'd0, vstip}, {63'd0, VECS[i].e_t});
      chk("R1 vseip", {63'd0, vseip}, {63'd0, VECS[i].e_e});
      chk("R3 sgeip", {63'd0, sgeip}, {63'd0, VECS[i].e_s});
    end
    time_now = 0; time_offset = 0; vs_cmp = '1; gext_pend = 0; plat_vseip = 0;

    // R4: bit 0 and upper bits cleared
    wr(W_HGEIE, 64'hFFFF_FFFF_FFFF_FFFF);
    gext_pend = 9'h1FF; #1;
    chk("R4 hgeie all ones", hgeie_rd, 64'h1FE);
    chk("R4 hgeip all ones", hgeip_rd, 64'h1FE);
    chk("R3 sgeip all", {63'd0, sgeip}, 64'd1);

    // R5: illegal selector ignored
    wr(W_HST, 64'd9 << 12);
    gext_pend = 9'h008; #1;
    chk("R5 illegal kept", {63'd0, vseip}, 64'd1);
    wr(W_HST, 64'd8 << 12);
    gext_pend = 9'h100; #1;
    chk("R5 legal max", {63'd0, vseip}, 64'd1);
    gext_pend = 9'h008; #1;
    chk("R5 old bit off", {63'd0, vseip}, 64'd0);

    // R9: selector zero
    wr(W_HST, 64'd0);
    gext_pend = 9'h1FF; #1;
    chk("R9 vseip none", {63'd0, vseip}, 64'd0);
    gext_pend = 0;
    wr(W_HGEIE, 64'd0);

    // R6: hip write touches only VSSIP
    wr(W_HIP, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R6 hvip after hip write", hvip_rd, 64'h4);
    chk("R6 hip view", hip_rd, 64'h4);

    // R7: alias paths
    wr(W_VSIP, 64'h4);
    chk("R7 vsip bit1 clears", {63'd0, vssip}, 64'd0);
    wr(W_VSIP, 64'h2);
    chk("R7 vsip bit1 sets", {63'd0, vssip}, 64'd1);
    wr(W_MIP, 64'h0);
    chk("R7 mip clears", {63'd0, vssip}, 64'd0);
    wr(W_MIP, 64'h4);
    chk("R7 mip sets", {63'd0, vssip}, 64'd1);
    wr(W_HVIP, 64'h440);
    chk("R7 hvip direct", hvip_rd, 64'h440);
    chk("R6 hip mirrors", hip_rd, 64'h440);
    chk("R2 stored timer", {63'd0, vstip}, 64'd1);
    chk("R1 stored ext", {63'd0, vseip}, 64'd1);

    // R10: write not visible before the edge
    @(negedge clk);
    wr_data = 64'h004; sel_hvip = 1; #1;
    chk("R10 same cycle", hvip_rd, 64'h440);
    @(negedge clk);
    sel_hvip = 0; wr_data = 0; #1;
    chk("R10 next cycle", hvip_rd, 64'h004);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule